// File: doc/BRIEF.md
# Automatic Sync Source Switch

This block decides whether a camera's timing chain follows an incoming composite sync or falls back to its own free-running timing. It watches the composite sync input, brings it into the reference clock domain, and counts transitions of either polarity. Enough transitions move the block into external mode. A run of line periods with no transition at all moves it back into internal mode.

The mode flag gates the outputs that only make sense while locked to an external source. These are the line-rate clock enable, the subcarrier clock enable, the oscillator enable and the line-switch error pulse. The block runs from a free-running reference clock and gets line-period timing from a one-cycle tick input, so it keeps deciding while the external-mode oscillators are stopped.

Entry and exit use different criteria. Entry counts transitions. Exit measures silence in line periods. This asymmetry keeps a noisy or briefly interrupted sync from toggling the mode on every glitch.

Top module: `sync_source_switch`

## Requirements
- R1: While internal, the tenth counted sync transition switches `ext_mode_o` high. A change on `sync_i` set up before clock edge k is counted at edge k+2, and `ext_mode_o` goes high at that edge when it is the tenth; nine transitions leave the mode internal.
- R2: While external, `ext_mode_o` goes low at the clock edge that samples the tenth consecutive `line_tick_i` pulse with no counted transition since the last one; nine such ticks leave the mode external.
- R3: While `ext_mode_o` is low, `line_clk_o`, `subc_clk_o` and `osc_en_o` are low. While it is high, `osc_en_o` is high and the two clock outputs follow `line_clk_i` and `subc_clk_i`.
- R4: While `ext_mode_o` is low, `lsw_err_o` is low. While it is high, `lsw_err_o` follows `lsw_err_i`.
- R5: The transition count saturates at ten. It is cleared whenever ten silent ticks elapse, in either mode, so transitions counted before such a silence do not add to later ones.
- R6: A counted transition restarts the silence count. When a transition and a tick are sampled at the same edge, the transition wins and the mode stays external.
- R7: After `rst_ni` is asserted, the mode is internal and every gated output is low.
- R8: Rising and falling transitions of `sync_i` count equally after a two-flop synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sync_i | input | 1 | Composite sync, asynchronous |
| line_tick_i | input | 1 | One-cycle pulse per line period |
| line_clk_i | input | 1 | Line-rate clock enable to be gated |
| subc_clk_i | input | 1 | Subcarrier clock enable to be gated |
| lsw_err_i | input | 1 | Line-switch error pulse to be gated |
| ext_mode_o | output | 1 | 1 = external sync, 0 = internal |
| osc_en_o | output | 1 | Oscillator enable, high in external mode |
| line_clk_o | output | 1 | Gated line-rate clock enable |
| subc_clk_o | output | 1 | Gated subcarrier clock enable |
| lsw_err_o | output | 1 | Gated line-switch error pulse |

## Verification
The hardest case to reach from the ports is a counted transition and a line tick at the same clock edge on the ninth silent tick. The transition must win there. The bench reaches it by counting the synchronizer delay: it toggles `sync_i` and raises the tick exactly two edges later. The counter-clear rule is exposed by a sequence of five transitions, ten silent ticks and then nine transitions. That sequence would enter external mode if the early count survived. The exact entry latency is checked one cycle before and at the predicted edge.

// File: rtl/sync_sw_pkg.sv
package sync_sw_pkg;
  localparam int unsigned SYNC_STAGES_DEF = 2;
  localparam int unsigned EDGE_TH_DEF     = 10;
  localparam int unsigned SILENCE_TH_DEF  = 10;

  typedef enum logic {
    MODE_INT = 1'b0,
    MODE_EXT = 1'b1
  } sync_mode_e;
endpackage

// File: rtl/sync_sw_edge_det.sv
module sync_sw_edge_det #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], sync_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  // either polarity counts
  assign edge_o = sync_q[STAGES-1] ^ last_q;
endmodule

// File: rtl/sync_sw_edge_cnt.sv
module sync_sw_edge_cnt #(
  parameter int unsigned TH = 10,
  localparam int unsigned W = $clog2(TH + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         edge_i,
  input  logic         clr_i,
  output logic         reach_o,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            cnt_q <= '0;
    else if (clr_i)                         cnt_q <= '0;
    else if (edge_i && cnt_q < W'(TH))      cnt_q <= cnt_q + 1'b1;
  end

  assign reach_o = edge_i && (cnt_q >= W'(TH - 1));
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/sync_sw_silence_cnt.sv
module sync_sw_silence_cnt #(
  parameter int unsigned TH = 10,
  localparam int unsigned W = $clog2(TH + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         edge_i,
  input  logic         tick_i,
  output logic         expire_o,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  assign expire_o = tick_i && !edge_i && (cnt_q == W'(TH - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (edge_i)   cnt_q <= '0;
    else if (tick_i)   cnt_q <= expire_o ? '0 : cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/sync_sw_out_gate.sv
module sync_sw_out_gate (
  input  logic ext_i,
  input  logic line_clk_i,
  input  logic subc_clk_i,
  input  logic lsw_err_i,
  output logic osc_en_o,
  output logic line_clk_o,
  output logic subc_clk_o,
  output logic lsw_err_o
);
  assign osc_en_o   = ext_i;
  assign line_clk_o = ext_i & line_clk_i;
  assign subc_clk_o = ext_i & subc_clk_i;
  assign lsw_err_o  = ext_i & lsw_err_i;
endmodule

// File: rtl/sync_source_switch.sv
module sync_source_switch
  import sync_sw_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF,
  parameter int unsigned EDGE_TH     = EDGE_TH_DEF,
  parameter int unsigned SILENCE_TH  = SILENCE_TH_DEF,
  localparam int unsigned EW = $clog2(EDGE_TH + 1),
  localparam int unsigned SW = $clog2(SILENCE_TH + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic line_tick_i,
  input  logic line_clk_i,
  input  logic subc_clk_i,
  input  logic lsw_err_i,
  output logic ext_mode_o,
  output logic osc_en_o,
  output logic line_clk_o,
  output logic subc_clk_o,
  output logic lsw_err_o
);
  logic          edge_seen;
  logic          reach;
  logic          expire;
  logic [EW-1:0] edge_cnt;
  logic [SW-1:0] silence_cnt;
  sync_mode_e    mode_q, mode_d;

  sync_sw_edge_det #(.STAGES(SYNC_STAGES)) i_edge_det (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sync_i (sync_i),
    .edge_o (edge_seen)
  );

  sync_sw_edge_cnt #(.TH(EDGE_TH)) i_edge_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .edge_i  (edge_seen),
    .clr_i   (expire),
    .reach_o (reach),
    .cnt_o   (edge_cnt)
  );

  sync_sw_silence_cnt #(.TH(SILENCE_TH)) i_silence_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .edge_i   (edge_seen),
    .tick_i   (line_tick_i),
    .expire_o (expire),
    .cnt_o    (silence_cnt)
  );

  always_comb begin
    mode_d = mode_q;
    if (expire)     mode_d = MODE_INT;
    else if (reach) mode_d = MODE_EXT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_INT;
    else         mode_q <= mode_d;
  end

  assign ext_mode_o = (mode_q == MODE_EXT);

  sync_sw_out_gate i_out_gate (
    .ext_i      (ext_mode_o),
    .line_clk_i (line_clk_i),
    .subc_clk_i (subc_clk_i),
    .lsw_err_i  (lsw_err_i),
    .osc_en_o   (osc_en_o),
    .line_clk_o (line_clk_o),
    .subc_clk_o (subc_clk_o),
    .lsw_err_o  (lsw_err_o)
  );
endmodule

// File: rtl/sync_source_switch_chk.sv
module sync_source_switch_chk #(
  parameter int unsigned EDGE_TH    = 10,
  parameter int unsigned SILENCE_TH = 10,
  localparam int unsigned EW = $clog2(EDGE_TH + 1),
  localparam int unsigned SW = $clog2(SILENCE_TH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          line_tick_i,
  input logic          edge_seen,
  input logic [EW-1:0] edge_cnt,
  input logic [SW-1:0] silence_cnt,
  input logic          ext_mode_o,
  input logic          osc_en_o,
  input logic          line_clk_o,
  input logic          subc_clk_o,
  input logic          lsw_err_o
);
  assert_ext_entry_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ext_mode_o) |-> $past(edge_seen));

  assert_int_entry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ext_mode_o) |-> ($past(line_tick_i) && !$past(edge_seen)));

  assert_clk_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_mode_o |-> (!line_clk_o && !subc_clk_o && !osc_en_o));

  assert_lsw_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_mode_o |-> !lsw_err_o);

  assert_no_overflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_cnt <= EW'(EDGE_TH));

  assert_silence_clr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_seen |=> (silence_cnt == '0));
endmodule

bind sync_source_switch sync_source_switch_chk #(
  .EDGE_TH    (EDGE_TH),
  .SILENCE_TH (SILENCE_TH)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .line_tick_i (line_tick_i),
  .edge_seen   (edge_seen),
  .edge_cnt    (edge_cnt),
  .silence_cnt (silence_cnt),
  .ext_mode_o  (ext_mode_o),
  .osc_en_o    (osc_en_o),
  .line_clk_o  (line_clk_o),
  .subc_clk_o  (subc_clk_o),
  .lsw_err_o   (lsw_err_o)
);

// File: tb/test_sync_source_switch.sv
`timescale 1ns/1ps
module test_sync_source_switch;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_in = 1'b0;
  logic tick = 1'b0;
  logic line_clk = 1'b1;
  logic subc_clk = 1'b1;
  logic lsw_err = 1'b1;
  logic ext_mode, osc_en, line_clk_g, subc_clk_g, lsw_err_g;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  sync_source_switch i_sync_source_switch (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .sync_i      (sync_in),
    .line_tick_i (tick),
    .line_clk_i  (line_clk),
    .subc_clk_i  (subc_clk),
    .lsw_err_i   (lsw_err),
    .ext_mode_o  (ext_mode),
    .osc_en_o    (osc_en),
    .line_clk_o  (line_clk_g),
    .subc_clk_o  (subc_clk_g),
    .lsw_err_o   (lsw_err_g)
  );

  // {edges[3:0], ticks[3:0], expected mode}
  localparam logic [8:0] VEC [12] = '{
    {4'd9, 4'd0, 1'b0},  // R1 nine is not enough
    {4'd1, 4'd0, 1'b1},  // R1 tenth enters external
    {4'd0, 4'd9, 1'b1},  // R2 nine silent ticks
    {4'd0, 4'd1, 1'b0},  // R2 tenth exits
    {4'd5, 4'd0, 1'b0},  // R5 partial count
    {4'd0, 4'd10, 1'b0}, // R5 silence clears count
    {4'd9, 4'd0, 1'b0},  // R5 old count gone
    {4'd1, 4'd0, 1'b1},  // R1/R8
    {4'd0, 4'd9, 1'b1},
    {4'd1, 4'd0, 1'b1},  // R6 edge restarts silence
    {4'd0, 4'd9, 1'b1},  // R6
    {4'd0, 4'd1, 1'b0}   // R2
  };

  task automatic check(input string req, input logic exp);
    logic [4:0] act, want;
    act  = {ext_mode, osc_en, line_clk_g, subc_clk_g, lsw_err_g};
    want = {5{exp}};
    n_chk++;
    if (act !== want) begin
      n_bad++;
      $display("FAIL %s: outputs %b expected %b", req, act, want);
    end
  endtask

  task automatic do_edges(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) sync_in = ~sync_in;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic do_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R7 in reset", 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R7 after reset", 1'b0);

    foreach (VEC[v]) begin
      do_edges(int'(VEC[v][8:5]));
      do_ticks(int'(VEC[v][4:1]));
      repeat (4) @(negedge clk);
      check($sformatf("R1/R2/R3/R4/R5/R6 vector %0d", v), VEC[v][0]);
    end

    // R1 latency: nine edges, then tenth toggled before edge k
    do_edges(9);
    @(negedge clk) sync_in = ~sync_in;
    @(negedge clk);
    @(negedge clk);
    check("R1 before edge k+2", 1'b0);
    @(negedge clk);
    check("R1 at edge k+2", 1'b1);

    // R3/R4 gated outputs follow inputs in external mode
    line_clk = 1'b0; subc_clk = 1'b1; lsw_err = 1'b0;
    @(negedge clk);
    n_chk++;
    if ({line_clk_g, subc_clk_g, lsw_err_g} !== 3'b010) begin
      n_bad++;
      $display("FAIL R3/R4 pass-through: %b expected 010",
               {line_clk_g, subc_clk_g, lsw_err_g});
    end
    line_clk = 1'b1; lsw_err = 1'b1;

    // R6 edge and tick at the same edge on the ninth silent tick
    do_ticks(9);
    @(negedge clk) sync_in = ~sync_in;
    @(negedge clk);
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    repeat (3) @(negedge clk);
    check("R6 edge beats tick", 1'b1);
    do_ticks(9);
    repeat (2) @(negedge clk);
    check("R6 silence restarted", 1'b1);
    do_ticks(1);
    repeat (2) @(negedge clk);
    check("R2 exit after restart", 1'b0);

    // R7 reset from external mode
    do_edges(10);
    repeat (2) @(negedge clk);
    check("R8 ten toggles enter", 1'b1);
    rst_n = 1'b0;
    @(negedge clk);
    check("R7 reset from external", 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R7 stays internal", 1'b0);

    finish_run();
  end
endmodule